// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Array Controller

This block models a one-bit-wide dynamic memory built as a square grid of cells, reached only through a row buffer. A request carries one address that splits into a row part and a column part. The controller first opens the row by copying the whole row into a set of column latches. The column part then selects one latch bit, which is read or overwritten. While a row stays open, later requests to that row only change the column, so they are served without reopening it. A read can also ask for a burst of four bits. These come from the four columns of the aligned group that holds the start column, and the block produces the column sequence itself.

Opening a different row first copies the latches back into the cells of the row being closed, and only then fetches the new row. A built-in timer raises a refresh request at a fixed cycle period. When the controller is idle, the refresh takes one cycle and walks the rows in turn. If the row being refreshed is the open row, the latch contents are written back to it. Refresh never closes the open row.

Requests use a valid/ready pair: a request is accepted on a rising clock edge where both `req_valid` and `ready` are high. Read data comes back on `rd_data`, qualified by `rd_valid` one bit per cycle.

Top module: `dram_rowbuf_ctrl`

## Requirements
- R1: After reset every cell reads 0, `ready` is high and `rd_valid` is low, and no row is open, so the first access always takes the row-open path.
- R2: The address field `req_addr` carries the row index in its upper log2(ROWS) bits and the column index in its lower log2(COLS) bits, so cell (row r, column c) sits at address r*COLS + c.
- R3: A single read to the open row drives `rd_valid` high with that column's bit in the cycle right after acceptance, and `ready` stays high.
- R4: A read to any row other than the open one (or when no row is open) delivers its first bit two cycles later than a hit would, and holds `ready` low for exactly those two cycles.
- R5: A write changes only the addressed bit, produces no `rd_valid`, and keeps `ready` high when it hits the open row. A read of that column accepted in any later cycle returns the new bit.
- R6: Bits written into an open row are still present after another row has been opened and the first row is reopened.
- R7: A burst read (`req_nibble` high, `req_write` low) returns four bits on four consecutive cycles, from columns (c div 4)*4 + ((c+i) mod 4) for i = 0..3. On a hit, `ready` stays low for the three cycles after the first bit.
- R8: On a write, `req_nibble` is ignored: exactly one bit is written, and the write takes the same cycles as a single write.
- R9: When idle, `ready` drops for exactly one cycle every REFRESH_INTERVAL cycles. This refresh wins over a request waiting in that cycle, and the request is accepted in the next cycle. Refresh keeps the open row open and preserves every stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write `req_wdata`, 0 = read |
| req_nibble | input | 1 | Burst of four on a read; ignored on a write |
| req_addr | input | log2(ROWS)+log2(COLS) | Row in the upper field, column in the lower field |
| req_wdata | input | 1 | Bit to write |
| ready | output | 1 | Controller can accept a request in this cycle |
| rd_valid | output | 1 | `rd_data` carries a read bit in this cycle |
| rd_data | output | 1 | Read bit |

## Verification
If the open-row record is wrong, the next access shows it one or two cycles after acceptance. A false hit returns the bit after one cycle instead of three, with data from the wrong row. A false miss costs two extra cycles of low `ready`. A lost write-back shows only later, when the closed row is reopened and read, so the bench reads across row switches and refresh periods. A wrong burst column counter shows on the second to fourth beat of a burst. A wrong refresh timer shows as a misplaced one-cycle dip in `ready`.

// File: rtl/drb_pkg.sv
package drb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DO    = 2'd2,
    ST_BURST = 2'd3
  } drb_state_e;

  // beats per nibble burst
  localparam int unsigned NIB_BEATS = 4;

  // Column of burst beat 'beat' when the burst starts at column 'base':
  // stays inside the aligned group of four, wraps modulo four.
  function automatic int nib_col(input int base, input int beat);
    return (base & ~3) | ((base + beat) & 3);
  endfunction

endpackage

// File: rtl/drb_cell_array.sv
module drb_cell_array #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32,
  localparam int unsigned RA_W = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_row,
  input  logic [COLS-1:0] wr_bits,
  input  logic [RA_W-1:0] rd_row,
  output logic [COLS-1:0] rd_bits
);

  logic [COLS-1:0] cells_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
    end else if (wr_en) begin
      cells_q[wr_row] <= wr_bits;
    end
  end

  assign rd_bits = cells_q[rd_row];

  // a row write stores exactly the bits presented (R6)
  assert_row_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells_q[$past(wr_row)] == $past(wr_bits));

endmodule

// File: rtl/drb_col_latch.sv
module drb_col_latch #(
  parameter int unsigned COLS = 32,
  localparam int unsigned CA_W = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [COLS-1:0] load_bits,
  input  logic            bit_we,
  input  logic [CA_W-1:0] bit_col,
  input  logic            bit_val,
  input  logic [CA_W-1:0] rd_col,
  output logic            rd_bit,
  output logic [COLS-1:0] row_bits
);

  logic [COLS-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (load_en) begin
      latch_q <= load_bits;
    end else if (bit_we) begin
      latch_q[bit_col] <= bit_val;
    end
  end

  assign rd_bit   = latch_q[rd_col];
  assign row_bits = latch_q;

  // the sequencer never loads a row and writes a column in the same cycle (R5)
  assert_load_write_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && bit_we));

  // a column write lands in the latch at once (R5)
  assert_col_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !load_en) |=> latch_q[$past(bit_col)] == $past(bit_val));

endmodule

// File: rtl/drb_refresh_timer.sv
module drb_refresh_timer #(
  parameter int unsigned ROWS             = 32,
  parameter int unsigned REFRESH_INTERVAL = 128,
  localparam int unsigned RA_W  = $clog2(ROWS),
  localparam int unsigned CNT_W = $clog2(REFRESH_INTERVAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  output logic            pend,
  output logic [RA_W-1:0] row
);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [RA_W-1:0]  row_q;
  logic             tick;

  assign tick = (cnt_q == CNT_W'(REFRESH_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      pend_q <= tick | (pend_q & ~ack);
      if (ack) row_q <= row_q + 1'b1;
    end
  end

  assign pend = pend_q;
  assign row  = row_q;

  // refresh is only taken when one is owed (R9)
  assert_ack_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend_q);

  // a taken refresh is cleared unless a new period ends in the same cycle (R9)
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick) |=> !pend_q);

endmodule

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl
  import drb_pkg::*;
#(
  parameter int unsigned ROWS             = 32,
  parameter int unsigned COLS             = 32,
  parameter int unsigned REFRESH_INTERVAL = 128,
  localparam int unsigned RA_W = $clog2(ROWS),
  localparam int unsigned CA_W = $clog2(COLS),
  localparam int unsigned AW   = RA_W + CA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_nibble,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic          rd_data
);

  // ---------------- sequencer state ----------------
  drb_state_e      state_q;
  logic [RA_W-1:0] open_row_q;
  logic            open_vld_q;
  logic [RA_W-1:0] p_row_q;
  logic [CA_W-1:0] p_col_q;
  logic            p_wr_q;
  logic            p_nib_q;
  logic            p_bit_q;
  logic [1:0]      beat_q;
  logic            rd_valid_q;
  logic            rd_data_q;

  // ---------------- named internal events ----------------
  logic [RA_W-1:0] req_row;
  logic [CA_W-1:0] req_col;
  logic            idle;
  logic            ref_pend;
  logic [RA_W-1:0] ref_row;
  logic            ref_fire;
  logic            accept;
  logic            row_hit;
  logic            acc_hit;
  logic            acc_miss;
  logic            acc_hit_rd;
  logic            acc_miss_rd;
  logic            acc_wr_hit;
  logic            load_fire;
  logic            do_fire;
  logic            acc_go;
  logic [CA_W-1:0] acc_col;
  logic            acc_wr;
  logic            acc_bit;
  logic [CA_W-1:0] burst_col;
  logic [CA_W-1:0] lat_rd_col;
  logic            lat_rd_bit;
  logic [COLS-1:0] lat_row_bits;
  logic [COLS-1:0] arr_rd_bits;
  logic            arr_we;
  logic            wb_close;
  logic            wb_refresh;

  assign req_row = req_addr[AW-1:CA_W];
  assign req_col = req_addr[CA_W-1:0];

  assign idle     = (state_q == ST_IDLE);
  assign ref_fire = idle & ref_pend;
  assign ready    = idle & ~ref_pend;
  assign accept   = ready & req_valid;

  assign row_hit     = open_vld_q & (req_row == open_row_q);
  assign acc_hit     = accept & row_hit;
  assign acc_miss    = accept & ~row_hit;
  assign acc_hit_rd  = acc_hit & ~req_write;
  assign acc_miss_rd = acc_miss & ~req_write;
  assign acc_wr_hit  = acc_hit & req_write;

  assign load_fire = (state_q == ST_LOAD);
  assign do_fire   = (state_q == ST_DO);

  // the column access happens either on a hit at acceptance or after a row open
  assign acc_go  = acc_hit | do_fire;
  assign acc_col = do_fire ? p_col_q : req_col;
  assign acc_wr  = do_fire ? p_wr_q  : req_write;
  assign acc_bit = do_fire ? p_bit_q : req_wdata;

  assign burst_col  = CA_W'(nib_col(int'(p_col_q), int'(beat_q)));
  assign lat_rd_col = (state_q == ST_BURST) ? burst_col : acc_col;

  // write-back: on closing a row, or when refresh reaches the open row
  assign wb_close   = acc_miss & open_vld_q;
  assign wb_refresh = ref_fire & open_vld_q & (ref_row == open_row_q);
  assign arr_we     = wb_close | wb_refresh;

  // ---------------- sub-blocks ----------------
  drb_cell_array #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_we),
    .wr_row  (open_row_q),
    .wr_bits (lat_row_bits),
    .rd_row  (p_row_q),
    .rd_bits (arr_rd_bits)
  );

  drb_col_latch #(
    .COLS (COLS)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_fire),
    .load_bits (arr_rd_bits),
    .bit_we    (acc_go & acc_wr),
    .bit_col   (acc_col),
    .bit_val   (acc_bit),
    .rd_col    (lat_rd_col),
    .rd_bit    (lat_rd_bit),
    .row_bits  (lat_row_bits)
  );

  drb_refresh_timer #(
    .ROWS             (ROWS),
    .REFRESH_INTERVAL (REFRESH_INTERVAL)
  ) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_fire),
    .pend  (ref_pend),
    .row   (ref_row)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      open_row_q <= '0;
      open_vld_q <= 1'b0;
      p_row_q    <= '0;
      p_col_q    <= '0;
      p_wr_q     <= 1'b0;
      p_nib_q    <= 1'b0;
      p_bit_q    <= 1'b0;
      beat_q     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            p_row_q <= req_row;
            p_col_q <= req_col;
            p_wr_q  <= req_write;
            p_nib_q <= req_nibble & ~req_write;
            p_bit_q <= req_wdata;
            if (row_hit) begin
              if (!req_write) begin
                rd_valid_q <= 1'b1;
                rd_data_q  <= lat_rd_bit;
                if (req_nibble) begin
                  state_q <= ST_BURST;
                  beat_q  <= 2'd1;
                end
              end
            end else begin
              state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          open_row_q <= p_row_q;
          open_vld_q <= 1'b1;
          state_q    <= ST_DO;
        end
        ST_DO: begin
          state_q <= ST_IDLE;
          if (!p_wr_q) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= lat_rd_bit;
            if (p_nib_q) begin
              state_q <= ST_BURST;
              beat_q  <= 2'd1;
            end
          end
        end
        ST_BURST: begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= lat_rd_bit;
          beat_q     <= beat_q + 2'd1;
          if (beat_q == 2'(NIB_BEATS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // ---------------- assertions ----------------
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_valid_q);

  assert_hit_read_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit_rd |=> rd_valid);

  assert_miss_two_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> !ready ##1 !ready);

  assert_miss_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss_rd |-> ##3 rd_valid);

  assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_hit |=> !rd_valid);

  assert_close_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> !arr_we);

  assert_burst_streams_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST) |-> rd_valid);

  assert_write_no_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (state_q != ST_BURST) ##1 (state_q != ST_BURST));

  assert_refresh_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> (!accept && !load_fire && !do_fire));

  assert_refresh_keeps_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> (open_vld_q == $past(open_vld_q)) && (open_row_q == $past(open_row_q)));

endmodule

// File: tb/sim_dram_rowbuf_ctrl.sv
`timescale 1ns/1ps
module sim_dram_rowbuf_ctrl;

  localparam int ROWS = 32;
  localparam int COLS = 32;
  localparam int RI   = 128;
  localparam int AW   = $clog2(ROWS) + $clog2(COLS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_nibble = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_wdata = 1'b0;
  logic          ready;
  logic          rd_valid;
  logic          rd_data;

  always #2.5 clk = ~clk;

  dram_rowbuf_ctrl #(
    .ROWS (ROWS), .COLS (COLS), .REFRESH_INTERVAL (RI)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_nibble (req_nibble), .req_addr (req_addr), .req_wdata (req_wdata),
    .ready (ready), .rd_valid (rd_valid), .rd_data (rd_data)
  );

  bit mem_m [ROWS*COLS];
  int open_m = -1;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // wait for a refresh dip, return in the first ready cycle after it
  task automatic sync_refresh();
    @(negedge clk);
    while (ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input bit nib, input int row, input int col,
                        input bit wb, output int lat, output int busy,
                        output int nb, output bit [3:0] bts);
    bit hi_seen;
    lat = 0; busy = 0; nb = 0; bts = '0; hi_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_nibble = nib;
    req_addr = AW'(row * COLS + col); req_wdata = wb;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_nibble = 1'b0; req_wdata = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (rd_valid) begin
        if (nb == 0) lat = k;
        if (nb < 4) bts[nb] = rd_data;
        nb++;
      end
      if (!hi_seen) begin
        if (ready) hi_seen = 1'b1;
        else busy++;
      end
      if (k < 8) @(negedge clk);
    end
    if (wr) mem_m[row * COLS + col] = wb;
    open_m = row;
  endtask

  task automatic checked_read(input string tag, input int row, input int col, input bit nib);
    int lat, busy, nb; bit [3:0] bts;
    bit hit = (open_m == row);
    access(1'b0, nib, row, col, 1'b0, lat, busy, nb, bts);
    chk(tag, lat, hit ? 1 : 3, "first-bit latency");
    chk(tag, nb, nib ? 4 : 1, "beat count");
    chk(tag, busy, hit ? (nib ? 3 : 0) : (nib ? 5 : 2), "ready-low cycles");
    for (int i = 0; i < (nib ? 4 : 1); i++) begin
      int c = (col / 4) * 4 + (col + i) % 4;
      chk(tag, bts[i], mem_m[row * COLS + c], $sformatf("data row %0d col %0d", row, c));
    end
  endtask

  task automatic checked_write(input string tag, input int row, input int col,
                               input bit nib, input bit val);
    int lat, busy, nb; bit [3:0] bts;
    bit hit = (open_m == row);
    access(1'b1, nib, row, col, val, lat, busy, nb, bts);
    chk(tag, nb, 0, "read strobes on a write");
    chk(tag, busy, hit ? 0 : 2, "ready-low cycles on a write");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", ready, 1, "ready after reset");
    chk("R1", rd_valid, 0, "rd_valid after reset");
    checked_read("R1", 0, 0, 1'b0);
    checked_read("R1", 17, 22, 1'b0);
  endtask

  task automatic t_page();
    sync_refresh();
    checked_read("R4", 6, 0, 1'b0);
    checked_read("R3", 6, 5, 1'b0);
    checked_read("R3", 6, 31, 1'b0);
  endtask

  task automatic t_write();
    sync_refresh();
    checked_write("R5", 6, 3, 1'b0, 1'b1);
    checked_read("R5", 6, 3, 1'b0);
    checked_write("R5", 6, 3, 1'b0, 1'b0);
    checked_read("R5", 6, 3, 1'b0);
    checked_write("R5", 6, 4, 1'b0, 1'b1);
    checked_read("R5", 6, 4, 1'b0);
  endtask

  task automatic t_writeback();
    sync_refresh();
    checked_write("R6", 2, 7, 1'b0, 1'b1);
    checked_write("R6", 2, 8, 1'b0, 1'b1);
    checked_read("R6", 11, 7, 1'b0);
    checked_read("R6", 2, 7, 1'b0);
    checked_read("R6", 2, 8, 1'b0);
    checked_read("R6", 6, 4, 1'b0);
  endtask

  task automatic t_nibble();
    sync_refresh();
    checked_write("R7", 7, 8, 1'b0, 1'b1);
    checked_write("R7", 7, 9, 1'b0, 1'b0);
    checked_write("R7", 7, 10, 1'b0, 1'b1);
    checked_write("R7", 7, 11, 1'b0, 1'b1);
    checked_read("R7", 7, 10, 1'b1);
    checked_read("R7", 9, 1, 1'b1);
    checked_read("R7", 7, 11, 1'b1);
  endtask

  task automatic t_addr();
    sync_refresh();
    checked_write("R2", 3, 1, 1'b0, 1'b1);
    checked_read("R2", 1, 3, 1'b0);
    checked_read("R2", 3, 1, 1'b0);
  endtask

  task automatic t_burst_write();
    sync_refresh();
    checked_write("R8", 4, 13, 1'b1, 1'b1);
    checked_read("R8", 4, 12, 1'b1);
  endtask

  task automatic t_refresh();
    int n;
    sync_refresh();
    checked_write("R9", 5, 9, 1'b0, 1'b1);
    sync_refresh();
    n = 0;
    while (ready && n < 2 * RI) begin
      n++;
      @(negedge clk);
    end
    chk("R9", n, RI - 1, "ready-high cycles between refresh dips");
    // this is a refresh cycle: present a hit read and expect it to wait one cycle
    req_valid = 1'b1; req_write = 1'b0; req_nibble = 1'b0;
    req_addr = AW'(5 * COLS + 9);
    @(posedge clk);
    @(negedge clk);
    chk("R9", ready, 1, "ready back after one refresh cycle");
    chk("R9", rd_valid, 0, "request held back by refresh");
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", rd_valid, 1, "open row still a hit after refresh");
    chk("R9", rd_data, 1, "data after refresh");
    repeat (3) @(negedge clk);
    repeat (3 * RI) @(negedge clk);
    sync_refresh();
    checked_read("R9", 2, 7, 1'b0);
    checked_read("R9", 7, 8, 1'b1);
    checked_read("R9", 6, 4, 1'b0);
    checked_read("R9", 5, 9, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_page();
    t_write();
    t_writeback();
    t_nibble();
    t_addr();
    t_burst_write();
    t_refresh();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule